// File: doc/BRIEF.md
# Banked Data-Space Address Former

This block turns the 8-bit file operand of an instruction into a 12-bit address in a 4096-byte data space. It also holds the data storage behind that space. In banked mode, a 4-bit bank register supplies the upper nibble of the address, so the space is seen as 16 banks of 256 bytes, with one bank active at a time. In access mode, the bank register is bypassed. Operands below a split point land at the bottom of bank 0, and operands at or above it land at the top of bank 15, where the special-function registers sit.

Two special-function locations live in the block itself. The bank register is one of them; software moves to another bank by writing this location. The other is the status register. When the current instruction also produces new arithmetic flags, the flag updates take precedence over a data write aimed at the status register. Banks that a mask parameter marks as absent read as zero and drop writes.

Each cycle the block accepts one operand, an optional write and an optional flag update. One cycle later it presents the formed address and the read data.

Top module: `banked_file_map`

## Requirements
- R1: With `acc_mode` low, `eff_addr` one cycle later equals {bank register, `fa`}, where the bank register value is the one held during the cycle the operand was presented.
- R2: With `acc_mode` high and `fa` below SPLIT (default 0x60), `eff_addr` one cycle later equals 0x000 | `fa`.
- R3: With `acc_mode` high and `fa` at or above SPLIT, `eff_addr` one cycle later equals 0xF00 | `fa`.
- R4: A write to address BSR_ADDR (default 0xFE0) loads `wr_data[3:0]` into the bank register, visible on `bank_sel` after the edge. A read of that address returns {0000, bank register}. The bank register changes on no other write.
- R5: An address whose bank has a 0 in BANK_MASK (default 0x803F: banks 0 to 5 and 15 present) reads 0x00, and a write to it alters no stored byte.
- R6: `rd_data` shows, one cycle after the operand, the byte held before that cycle's write. A write to the same address in the same cycle does not affect that read.
- R7: When `flag_upd` is high, status bits [4:0] take `flag_val` (bit 0 carry, 1 digit carry, 2 zero, 3 overflow, 4 negative), even if the same cycle writes the status address.
- R8: A write to STAT_ADDR (default 0xFD8) always loads status bits [7:5] from `wr_data`. It also loads bits [4:0] when `flag_upd` is low. A read of that address returns the status value held before the cycle.
- R9: While `rst` is high, `bank_sel`, `status_q`, `eff_addr` and `rd_data` are all zero.
- R10: A byte written to a present, non-special address reads back unchanged later. The same operand in a different bank is a separate location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fa | input | 8 | File operand from the instruction |
| acc_mode | input | 1 | 1 selects access mapping, 0 selects banked mapping |
| wr_en | input | 1 | Write `wr_data` to the formed address |
| wr_data | input | 8 | Write data |
| flag_upd | input | 1 | The instruction produces new arithmetic flags |
| flag_val | input | 5 | New flag values |
| rd_data | output | 8 | Read data, one cycle after the operand |
| eff_addr | output | 12 | Formed address, one cycle after the operand |
| bank_sel | output | 4 | Current bank register |
| status_q | output | 8 | Current status register |

## Verification
A wrong bank register value shows at the ports within one cycle. It appears directly on `bank_sel`, and it appears in the upper nibble of the next banked `eff_addr`. A corrupted status byte is visible on `status_q` right after the faulty edge. A misrouted or wrongly enabled write stays hidden until that location is read again, so the stimulus returns to written addresses across several banks. It also reads back operands after writes aimed at absent banks. A fault in the access-mode split shows on `eff_addr` one cycle after an operand near the boundary.

// File: rtl/bfm_pkg.sv
package bfm_pkg;
  localparam int FLAG_W = 5;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_SPEC = 2'd2
  } rd_src_e;
endpackage

// File: rtl/bfm_addr_gen.sv
module bfm_addr_gen #(
  parameter int FA_W   = 8,
  parameter int BANK_W = 4,
  parameter int SPLIT  = 8'h60
) (
  input  logic [FA_W-1:0]        fa,
  input  logic                   acc_mode,
  input  logic [BANK_W-1:0]      bank,
  output logic [FA_W+BANK_W-1:0] addr
);
  localparam logic [FA_W-1:0] SPLIT_V = SPLIT[FA_W-1:0];

  always_comb begin
    if (!acc_mode)
      addr = {bank, fa};
    else if (fa < SPLIT_V)
      addr = {{BANK_W{1'b0}}, fa};
    else
      addr = {{BANK_W{1'b1}}, fa};
  end
endmodule

// File: rtl/bfm_bank_ram.sv
module bfm_bank_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bfm_status_reg.sv
module bfm_status_reg
  import bfm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [DW-1:0]     wr_data,
  input  logic              flag_upd,
  input  logic [FLAG_W-1:0] flag_val,
  output logic [DW-1:0]     status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else if (wr_hit) begin
      status[DW-1:FLAG_W] <= wr_data[DW-1:FLAG_W];
      status[FLAG_W-1:0]  <= flag_upd ? flag_val : wr_data[FLAG_W-1:0];
    end else if (flag_upd) begin
      status[FLAG_W-1:0] <= flag_val;
    end
  end
endmodule

// File: rtl/banked_file_map.sv
module banked_file_map
  import bfm_pkg::*;
#(
  parameter int FA_W      = 8,
  parameter int BANK_W    = 4,
  parameter int DW        = 8,
  parameter int SPLIT     = 8'h60,
  parameter logic [(1<<BANK_W)-1:0] BANK_MASK = 16'h803F,
  parameter int BSR_ADDR  = 12'hFE0,
  parameter int STAT_ADDR = 12'hFD8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FA_W-1:0]        fa,
  input  logic                   acc_mode,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data,
  input  logic                   flag_upd,
  input  logic [FLAG_W-1:0]      flag_val,
  output logic [DW-1:0]          rd_data,
  output logic [FA_W+BANK_W-1:0] eff_addr,
  output logic [BANK_W-1:0]      bank_sel,
  output logic [DW-1:0]          status_q
);
  localparam int ADDR_W = FA_W + BANK_W;
  localparam int NBANK  = 1 << BANK_W;
  localparam logic [ADDR_W-1:0] BSR_A  = ADDR_W'(BSR_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [ADDR_W-1:0] cur_addr;
  logic [BANK_W-1:0] cur_bank;
  logic              bank_impl, hit_bsr, hit_stat, ram_we;
  logic [BANK_W-1:0] bsr_q;
  logic [DW-1:0]     bank_rd [NBANK];
  rd_src_e           src_q;
  logic [BANK_W-1:0] rd_bank_q;
  logic [DW-1:0]     spec_q;

  bfm_addr_gen #(.FA_W(FA_W), .BANK_W(BANK_W), .SPLIT(SPLIT)) u_agen (
    .fa(fa), .acc_mode(acc_mode), .bank(bsr_q), .addr(cur_addr)
  );

  assign cur_bank  = cur_addr[ADDR_W-1:FA_W];
  assign bank_impl = BANK_MASK[cur_bank];
  assign hit_bsr   = (cur_addr == BSR_A);
  assign hit_stat  = (cur_addr == STAT_A);
  assign ram_we    = wr_en && bank_impl && !hit_bsr && !hit_stat;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (BANK_MASK[b]) begin : g_impl
      bfm_bank_ram #(.DW(DW), .AW(FA_W)) u_ram (
        .clk(clk),
        .we(ram_we && (cur_bank == BANK_W'(b))),
        .addr(cur_addr[FA_W-1:0]),
        .wdata(wr_data),
        .rdata(bank_rd[b])
      );
    end else begin : g_void
      assign bank_rd[b] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bsr_q <= '0;
    end else if (wr_en && hit_bsr) begin
      bsr_q <= wr_data[BANK_W-1:0];
    end
  end

  bfm_status_reg #(.DW(DW)) u_stat (
    .clk(clk), .rst(rst), .wr_hit(wr_en && hit_stat), .wr_data(wr_data),
    .flag_upd(flag_upd), .flag_val(flag_val), .status(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= SRC_NONE;
      rd_bank_q <= '0;
      spec_q    <= '0;
      eff_addr  <= '0;
    end else begin
      eff_addr  <= cur_addr;
      rd_bank_q <= cur_bank;
      spec_q    <= hit_bsr ? DW'(bsr_q) : status_q;
      if (hit_bsr || hit_stat) src_q <= SRC_SPEC;
      else if (bank_impl)      src_q <= SRC_RAM;
      else                     src_q <= SRC_NONE;
    end
  end

  always_comb begin
    case (src_q)
      SRC_SPEC: rd_data = spec_q;
      SRC_RAM:  rd_data = bank_rd[rd_bank_q];
      default:  rd_data = '0;
    endcase
  end

  assign bank_sel = bsr_q;
endmodule

// File: rtl/bfm_checker.sv
module bfm_checker #(
  parameter int FA_W   = 8,
  parameter int BANK_W = 4,
  parameter int DW     = 8,
  parameter int SPLIT  = 8'h60
) (
  input logic                   clk,
  input logic                   rst,
  input logic [FA_W-1:0]        fa,
  input logic                   acc_mode,
  input logic                   wr_en,
  input logic [DW-1:0]          wr_data,
  input logic                   flag_upd,
  input logic [4:0]             flag_val,
  input logic [DW-1:0]          rd_data,
  input logic [FA_W+BANK_W-1:0] eff_addr,
  input logic [BANK_W-1:0]      bank_sel,
  input logic [DW-1:0]          status_q,
  input logic                   bank_impl,
  input logic                   hit_bsr,
  input logic                   hit_stat
);
  localparam logic [FA_W-1:0] SPLIT_V = SPLIT[FA_W-1:0];

  assert_banked_R1: assert property (@(posedge clk) disable iff (rst)
    !acc_mode |=> eff_addr == {$past(bank_sel), $past(fa)});

  assert_acc_low_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_mode && fa < SPLIT_V) |=> eff_addr == {{BANK_W{1'b0}}, $past(fa)});

  assert_acc_high_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_mode && fa >= SPLIT_V) |=> eff_addr == {{BANK_W{1'b1}}, $past(fa)});

  assert_bank_load_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_bsr) |=> bank_sel == $past(wr_data[BANK_W-1:0]));

  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_bsr) |=> $stable(bank_sel));

  assert_absent_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (!bank_impl && !hit_bsr && !hit_stat) |=> rd_data == '0);

  assert_flag_guard_R7: assert property (@(posedge clk) disable iff (rst)
    flag_upd |=> status_q[4:0] == $past(flag_val));

  assert_upper_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_stat) |=> status_q[DW-1:5] == $past(wr_data[DW-1:5]));
endmodule

bind banked_file_map bfm_checker #(
  .FA_W(FA_W), .BANK_W(BANK_W), .DW(DW), .SPLIT(SPLIT)
) u_chk (
  .clk(clk), .rst(rst), .fa(fa), .acc_mode(acc_mode), .wr_en(wr_en),
  .wr_data(wr_data), .flag_upd(flag_upd), .flag_val(flag_val),
  .rd_data(rd_data), .eff_addr(eff_addr), .bank_sel(bank_sel),
  .status_q(status_q), .bank_impl(bank_impl), .hit_bsr(hit_bsr),
  .hit_stat(hit_stat)
);

// File: tb/sim_banked_file_map.sv
module sim_banked_file_map;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  fa = '0;
  logic        acc_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        flag_upd = 1'b0;
  logic [4:0]  flag_val = '0;
  logic [7:0]  rd_data;
  logic [11:0] eff_addr;
  logic [3:0]  bank_sel;
  logic [7:0]  status_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int m_bsr = 0;
  int m_stat = 0;
  int m_mem [int];
  localparam int SPLIT_T = 'h60;
  localparam int MASK_T  = 'h803F;

  always #4 clk = ~clk;

  banked_file_map u0 (
    .clk(clk), .rst(rst), .fa(fa), .acc_mode(acc_mode), .wr_en(wr_en),
    .wr_data(wr_data), .flag_upd(flag_upd), .flag_val(flag_val),
    .rd_data(rd_data), .eff_addr(eff_addr), .bank_sel(bank_sel),
    .status_q(status_q)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step(input int f, input bit a, input bit w, input int d,
                      input bit fu, input int fv);
    int ea, erd, nst;
    bit known;
    string atag, rtag, stag;
    fa = f[7:0]; acc_mode = a; wr_en = w; wr_data = d[7:0];
    flag_upd = fu; flag_val = fv[4:0];
    if (!a) begin ea = (m_bsr << 8) | f; atag = "R1"; end
    else if (f < SPLIT_T) begin ea = f; atag = "R2"; end
    else begin ea = 'hF00 | f; atag = "R3"; end
    known = 1;
    if (ea == 'hFE0) begin erd = m_bsr; rtag = "R4"; end
    else if (ea == 'hFD8) begin erd = m_stat; rtag = "R8"; end
    else if (((MASK_T >> (ea >> 8)) & 1) == 0) begin erd = 0; rtag = "R5"; end
    else begin
      rtag = w ? "R6" : "R10";
      if (m_mem.exists(ea)) erd = m_mem[ea]; else begin erd = 0; known = 0; end
    end
    nst = m_stat;
    stag = "R8";
    if (w && ea == 'hFD8) begin
      nst = (d & 'hE0) | (fu ? fv : (d & 'h1F));
      if (fu) stag = "R7";
    end else if (fu) begin
      nst = (m_stat & 'hE0) | fv;
      stag = "R7";
    end
    @(posedge clk);
    m_stat = nst;
    if (w && ea == 'hFE0) m_bsr = d & 'hF;
    else if (w && ea != 'hFD8 && ((MASK_T >> (ea >> 8)) & 1) == 1) m_mem[ea] = d;
    @(negedge clk);
    chk(atag, int'(eff_addr), ea);
    if (known) chk(rtag, int'(rd_data), erd);
    chk("R4", int'(bank_sel), m_bsr);
    chk(stag, int'(status_q), m_stat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs held at zero during reset
    chk("R9", int'(bank_sel), 0);
    chk("R9", int'(status_q), 0);
    chk("R9", int'(eff_addr), 0);
    chk("R9", int'(rd_data), 0);
    rst = 1'b0;
    // R4: select bank 3 via access-mode view of the bank register
    step('hE0, 1, 1, 'hF3, 0, 0);
    step('h10, 0, 1, 'hA5, 0, 0);          // R10 write 0x310
    step('h10, 0, 1, 'h5A, 0, 0);          // R6 read-before-write
    step('h10, 0, 0, 0, 0, 0);             // R10 read back
    step('hE0, 1, 0, 0, 0, 0);             // R4 read bank register
    // R5: bank 6 absent
    step('hE0, 1, 1, 'h06, 0, 0);
    step('h10, 0, 1, 'h77, 0, 0);
    step('h10, 0, 0, 0, 0, 0);
    step('hE0, 1, 1, 'h03, 0, 0);
    step('h10, 0, 0, 0, 0, 0);             // R10 still 0x5A in bank 3
    // R2/R3 split boundaries
    step('h5F, 1, 1, 'h11, 0, 0);
    step('h60, 1, 1, 'h22, 0, 0);
    step('h5F, 1, 0, 0, 0, 0);
    step('h60, 1, 0, 0, 0, 0);
    step('h00, 1, 1, 'h33, 0, 0);
    step('hFF, 1, 1, 'h44, 0, 0);
    // R7/R8 status guarding
    step('hD8, 1, 1, 'hEA, 1, 'h15);
    step('hD8, 1, 1, 'h0A, 0, 0);
    step('h40, 1, 0, 0, 1, 'h1F);
    step('hD8, 1, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      step($urandom % 256, 1'($urandom), 1'($urandom), $urandom % 256,
           1'($urandom), $urandom % 32);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule